// File: doc/BRIEF.md
# Deferred Field Patch Unit

This unit sits beside a trace array and owns its single write port. When a command arrives, the unit writes the whole entry straight away. Any field whose value depends on data that has not arrived yet is written as zero. Commands that carry data have their data beats arrive later, in command order, on a separate beat bus. The unit folds the beats of one transfer into a single value and then rewrites only those fields of the earlier entry.

For a store, the value is a chunk mask. For a DMA command, it is a start address plus a beat count. Response commands are never recorded. Their transfers are still consumed, so the beat stream stays aligned with the command stream.

A finished value goes to the array at once when the port is idle and nothing older is waiting. Otherwise it waits in a small queue, which drains on any cycle without a command write. When the queue is full and a new value arrives while the port is busy, the oldest waiting value is discarded. Its entry then keeps zero in the deferred fields.

Top module: `dmerge_top`

## Requirements
- R1: While reset is asserted and on idle cycles after it, `wr_en` is 0 and nothing is waiting for the port.
- R2: A command of kind 0 (plain) makes, one cycle later, a full write (`wr_full`=1, `wr_adr_en`=1) carrying its index, address and tag, with `wr_aux`=0.
- R3: A store command (kind 1) is first written with its address and `wr_aux`=0. A DMA command (kind 2) is first written with `wr_adr`=0 and `wr_aux`=0.
- R4: A response command (kind 3) causes no array write. Its beat transfer is still consumed in command order, and no patch is produced for it.
- R5: For a store, each beat whose 16-bit byte mask is nonzero sets bit `dat_sub` (address bits 6:4) of an 8-bit chunk mask. Beats accumulate up to and including the beat with `dat_eow`=1. The patch has `wr_full`=0, `wr_adr_en`=0 and `wr_aux`=mask.
- R6: For DMA, the patch has `wr_adr_en`=1, `wr_adr` equal to the first beat's `dat_word`, and `wr_aux` equal to the beat count, saturating at 255.
- R7: If no command write occurs and no patch is waiting, a finished patch appears on the port the cycle after its end-of-write beat.
- R8: A command write always wins the port. When it coincides with a finished patch, the command is written first and the patch is written later.
- R9: Waiting patches leave oldest first, one per cycle, on every cycle without a command write.
- R10: Four patches can wait. A fifth that arrives while the port is busy discards the oldest, which is never written.
- R11: Beats that arrive when no transfer is outstanding are ignored. They cause no write and do not alter a later transfer's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | 0 plain, 1 store, 2 DMA, 3 response |
| cmd_idx | input | IDX_W | Array entry assigned to the command |
| cmd_adr | input | ADR_W | Command address |
| cmd_tag | input | TAG_W | Remaining command fields |
| dat_valid | input | 1 | Data beat present |
| dat_eow | input | 1 | Last beat of the transfer |
| dat_sub | input | SUB_W | Chunk number (address bits 6:4) |
| dat_mask | input | MASK_W | Byte mask of the beat |
| dat_word | input | ADR_W | Beat payload (DMA address on first beat) |
| wr_en | output | 1 | Array write this cycle |
| wr_full | output | 1 | 1 full entry write, 0 field patch |
| wr_adr_en | output | 1 | Address field is written |
| wr_idx | output | IDX_W | Target entry |
| wr_adr | output | ADR_W | Address field value |
| wr_aux | output | 2**SUB_W | Mask or length field value |
| wr_tag | output | TAG_W | Command fields (0 on patches) |

## Verification
A corrupted accumulator shows up as a wrong `wr_aux` or `wr_adr` in the patch, one cycle after the end-of-write beat. A slipped transfer order queue shows up as a patch aimed at the wrong `wr_idx`, or as a patch that is missing entirely, on that same cycle. A damaged pointer in the patch queue only becomes visible once the port frees up. It then appears within at most four cycles as patches out of order, repeated, or missing. The directed scenarios therefore block the port on purpose, then release it and read the drain sequence one cycle at a time.

// File: rtl/dmerge_pkg.sv
package dmerge_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_STORE = 2'd1,
    K_DMA   = 2'd2,
    K_RESP  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/dmerge_order_q.sv
module dmerge_order_q #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  dmerge_pkg::cmd_kind_e push_kind,
  input  logic [IDX_W-1:0]      push_idx,
  input  logic                  pop,
  output dmerge_pkg::cmd_kind_e head_kind,
  output logic [IDX_W-1:0]      head_idx,
  output logic                  nonempty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SLOT_W = 2 + IDX_W;

  logic [SLOT_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rd_p, wr_p;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty  = (cnt != '0);
  assign head_kind = dmerge_pkg::cmd_kind_e'(slots[rd_p][SLOT_W-1 -: 2]);
  assign head_idx  = slots[rd_p][IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (push) slots[wr_p] <= {push_kind, push_idx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= ptr_next(wr_p);
      if (pop)  rd_p <= ptr_next(rd_p);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dmerge_accum.sv
module dmerge_accum #(
  parameter int SUB_W  = 3,
  parameter int MASK_W = 16,
  parameter int ADR_W  = 16,
  localparam int AUX_W = 1 << SUB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat,
  input  dmerge_pkg::cmd_kind_e kind,
  input  logic                  eow,
  input  logic [SUB_W-1:0]      sub,
  input  logic [MASK_W-1:0]     mask,
  input  logic [ADR_W-1:0]      word,
  output logic [AUX_W-1:0]      res_aux,
  output logic [ADR_W-1:0]      res_adr
);
  import dmerge_pkg::*;

  logic [AUX_W-1:0] acc_aux;
  logic [ADR_W-1:0] acc_adr;
  logic             started;

  function automatic logic [AUX_W-1:0] chunk_bit(input logic [SUB_W-1:0] s,
                                                 input logic any);
    logic [AUX_W-1:0] r;
    r = '0;
    r[s] = any;
    return r;
  endfunction

  function automatic logic [AUX_W-1:0] sat_inc(input logic [AUX_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_comb begin
    res_aux = acc_aux;
    res_adr = acc_adr;
    case (kind)
      K_STORE: res_aux = acc_aux | chunk_bit(sub, |mask);
      K_DMA: begin
        res_aux = sat_inc(acc_aux);
        if (!started) res_adr = word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_aux <= '0;
      acc_adr <= '0;
      started <= 1'b0;
    end else if (beat) begin
      if (eow) begin
        acc_aux <= '0;
        acc_adr <= '0;
        started <= 1'b0;
      end else begin
        acc_aux <= res_aux;
        acc_adr <= res_adr;
        started <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmerge_lossy_fifo.sv
module dmerge_lossy_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_p, wr_p;
  logic [CNT_W-1:0] cnt;
  logic             advance;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign drop    = push && full && !pop;
  assign advance = pop || drop;
  assign dout    = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push)    wr_p <= ptr_next(wr_p);
      if (advance) rd_p <= ptr_next(rd_p);
      if (push && !advance)      cnt <= cnt + 1'b1;
      else if (advance && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dmerge_top.sv
module dmerge_top #(
  parameter int IDX_W     = 5,
  parameter int ADR_W     = 16,
  parameter int TAG_W     = 8,
  parameter int SUB_W     = 3,
  parameter int MASK_W    = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int ORD_DEPTH = 8,
  localparam int AUX_W    = 1 << SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ADR_W-1:0]  cmd_adr,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic              dat_valid,
  input  logic              dat_eow,
  input  logic [SUB_W-1:0]  dat_sub,
  input  logic [MASK_W-1:0] dat_mask,
  input  logic [ADR_W-1:0]  dat_word,
  output logic              wr_en,
  output logic              wr_full,
  output logic              wr_adr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [ADR_W-1:0]  wr_adr,
  output logic [AUX_W-1:0]  wr_aux,
  output logic [TAG_W-1:0]  wr_tag
);
  import dmerge_pkg::*;

  localparam int SLOT_W = IDX_W + 1 + ADR_W + AUX_W;

  cmd_kind_e        kind_in, head_kind;
  logic [IDX_W-1:0] head_idx;
  logic             oq_nonempty;
  logic             beat_en;
  logic [AUX_W-1:0] acc_aux;
  logic [ADR_W-1:0] acc_adr;

  // named events, observed by the checker
  logic              ev_cmd_wr, ev_res, ev_pop, ev_direct, ev_drop;
  logic              fifo_empty, fifo_full;
  logic [IDX_W-1:0]  res_idx;
  logic              res_adr_en;
  logic [ADR_W-1:0]  res_adr;
  logic [SLOT_W-1:0] res_slot, head_slot;

  assign kind_in = cmd_kind_e'(cmd_kind);
  assign beat_en = dat_valid && oq_nonempty;

  dmerge_order_q #(.DEPTH(ORD_DEPTH), .IDX_W(IDX_W)) order_i (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_valid && kind_in != K_PLAIN),
    .push_kind(kind_in), .push_idx(cmd_idx),
    .pop(beat_en && dat_eow),
    .head_kind(head_kind), .head_idx(head_idx), .nonempty(oq_nonempty)
  );

  dmerge_accum #(.SUB_W(SUB_W), .MASK_W(MASK_W), .ADR_W(ADR_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .beat(beat_en), .kind(head_kind),
    .eow(dat_eow), .sub(dat_sub), .mask(dat_mask), .word(dat_word),
    .res_aux(acc_aux), .res_adr(acc_adr)
  );

  assign ev_cmd_wr  = cmd_valid && kind_in != K_RESP;
  assign ev_res     = beat_en && dat_eow && head_kind != K_RESP;
  assign ev_pop     = !ev_cmd_wr && !fifo_empty;
  assign ev_direct  = ev_res && !ev_cmd_wr && fifo_empty;
  assign res_idx    = head_idx;
  assign res_adr_en = (head_kind == K_DMA);
  assign res_adr    = res_adr_en ? acc_adr : '0;
  assign res_slot   = {res_idx, res_adr_en, res_adr, acc_aux};

  dmerge_lossy_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(ev_res && !ev_direct), .pop(ev_pop),
    .din(res_slot), .dout(head_slot),
    .empty(fifo_empty), .full(fifo_full), .drop(ev_drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0; wr_full <= 1'b0; wr_adr_en <= 1'b0;
      wr_idx <= '0; wr_adr <= '0; wr_aux <= '0; wr_tag <= '0;
    end else begin
      wr_en <= ev_cmd_wr || ev_pop || ev_direct;
      wr_full <= 1'b0; wr_adr_en <= 1'b0;
      wr_idx <= '0; wr_adr <= '0; wr_aux <= '0; wr_tag <= '0;
      if (ev_cmd_wr) begin
        wr_full   <= 1'b1;
        wr_adr_en <= 1'b1;
        wr_idx    <= cmd_idx;
        wr_adr    <= (kind_in == K_DMA) ? '0 : cmd_adr;
        wr_tag    <= cmd_tag;
      end else if (ev_pop) begin
        {wr_idx, wr_adr_en, wr_adr, wr_aux} <= head_slot;
      end else if (ev_direct) begin
        {wr_idx, wr_adr_en, wr_adr, wr_aux} <= res_slot;
      end
    end
  end
endmodule

// File: rtl/dmerge_checker.sv
module dmerge_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic             dat_valid,
  input logic             wr_en,
  input logic             wr_full,
  input logic [IDX_W-1:0] wr_idx,
  input logic             ev_cmd_wr,
  input logic             ev_res,
  input logic             ev_pop,
  input logic             ev_direct,
  input logic             ev_drop,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             oq_nonempty,
  input logic [IDX_W-1:0] res_idx
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !wr_en);

  assert_cmd_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind != 2'd3) |=> (wr_en && wr_full));

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmd_wr, ev_pop, ev_direct}));

  assert_resp_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd3 && fifo_empty && !ev_res) |=> !wr_en);

  assert_direct_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_res && !ev_cmd_wr && fifo_empty) |=>
      (wr_en && !wr_full && wr_idx == $past(res_idx)));

  assert_drain_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_kind != 2'd3) && !fifo_empty) |=> (wr_en && !wr_full));

  assert_drop_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> (fifo_full && ev_cmd_wr));

  assert_stray_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !oq_nonempty && !cmd_valid && fifo_empty) |=> !wr_en);
endmodule

bind dmerge_top dmerge_checker #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .dat_valid(dat_valid), .wr_en(wr_en), .wr_full(wr_full), .wr_idx(wr_idx),
  .ev_cmd_wr(ev_cmd_wr), .ev_res(ev_res), .ev_pop(ev_pop),
  .ev_direct(ev_direct), .ev_drop(ev_drop), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .oq_nonempty(oq_nonempty), .res_idx(res_idx)
);

// File: tb/dmerge_top_tb_top.sv
`timescale 1ns/1ps
module dmerge_top_tb_top;
  localparam int IDX_W = 5, ADR_W = 16, TAG_W = 8, SUB_W = 3, MASK_W = 16;
  localparam int AUX_W = 1 << SUB_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid; logic [1:0] cmd_kind; logic [IDX_W-1:0] cmd_idx;
  logic [ADR_W-1:0] cmd_adr; logic [TAG_W-1:0] cmd_tag;
  logic dat_valid, dat_eow; logic [SUB_W-1:0] dat_sub;
  logic [MASK_W-1:0] dat_mask; logic [ADR_W-1:0] dat_word;
  logic wr_en, wr_full, wr_adr_en; logic [IDX_W-1:0] wr_idx;
  logic [ADR_W-1:0] wr_adr; logic [AUX_W-1:0] wr_aux; logic [TAG_W-1:0] wr_tag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dmerge_top dut_i (.*);

  task automatic clear_in();
    cmd_valid = 0; cmd_kind = 0; cmd_idx = 0; cmd_adr = 0; cmd_tag = 0;
    dat_valid = 0; dat_eow = 0; dat_sub = 0; dat_mask = 0; dat_word = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic put_cmd(input logic [1:0] k, input int idx, input int adr, input int tag);
    cmd_valid = 1; cmd_kind = k; cmd_idx = IDX_W'(idx);
    cmd_adr = ADR_W'(adr); cmd_tag = TAG_W'(tag);
  endtask

  task automatic put_beat(input int sub, input int mask, input int word, input bit eow);
    dat_valid = 1; dat_sub = SUB_W'(sub); dat_mask = MASK_W'(mask);
    dat_word = ADR_W'(word); dat_eow = eow;
  endtask

  task automatic expect_none(input string req);
    checks++;
    if (wr_en !== 1'b0) begin
      fails++;
      $display("FAIL %s: wr_en=%b expected 0", req, wr_en);
    end
  endtask

  task automatic expect_wr(input string req, input bit full, input bit aen,
                           input int idx, input int adr, input int aux, input int tag);
    logic [3+IDX_W+ADR_W+AUX_W+TAG_W-1:0] act, exp;
    checks++;
    act = {wr_en, wr_full, wr_adr_en, wr_idx, wr_adr, wr_aux, wr_tag};
    exp = {1'b1, full, aen, IDX_W'(idx), ADR_W'(adr), AUX_W'(aux), TAG_W'(tag)};
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual en/full/aen/idx/adr/aux/tag=%b/%b/%b/%h/%h/%h/%h expected %b/%b/%b/%h/%h/%h/%h",
               req, wr_en, wr_full, wr_adr_en, wr_idx, wr_adr, wr_aux, wr_tag,
               1'b1, full, aen, IDX_W'(idx), ADR_W'(adr), AUX_W'(aux), TAG_W'(tag));
    end
  endtask

  task automatic t_reset();
    tick(); expect_none("R1 reset");
    tick(); expect_none("R1 idle");
  endtask

  task automatic t_plain();
    put_cmd(0, 3, 'h1234, 'h5A); tick(); expect_wr("R2 plain", 1, 1, 3, 'h1234, 0, 'h5A);
    tick(); expect_none("R2 single write");
  endtask

  task automatic t_store();
    put_cmd(1, 4, 'hBEEF, 1); tick(); expect_wr("R3 store first", 1, 1, 4, 'hBEEF, 0, 1);
    put_beat(2, 'h00F0, 0, 0); tick(); expect_none("R5 mid beat");
    put_beat(5, 0, 0, 0); tick(); expect_none("R5 zero-mask beat");
    put_beat(7, 1, 0, 1); tick(); expect_wr("R5 R7 store patch", 0, 0, 4, 0, 'h84, 0);
  endtask

  task automatic t_dma();
    put_cmd(2, 6, 'h7777, 2); tick(); expect_wr("R3 dma first", 1, 1, 6, 0, 0, 2);
    put_beat(0, 0, 'h4400, 0); tick();
    put_beat(0, 0, 'h1111, 0); tick();
    put_beat(0, 0, 'h2222, 1); tick(); expect_wr("R6 dma patch", 0, 1, 6, 'h4400, 3, 0);
  endtask

  task automatic t_dma_sat();
    put_cmd(2, 7, 'h1, 3); tick(); expect_wr("R3 dma first", 1, 1, 7, 0, 0, 3);
    for (int i = 0; i < 300; i++) begin
      put_beat(0, 0, (i == 0) ? 'h0ABC : i, i == 299); tick();
      if (i == 150) expect_none("R6 during long transfer");
    end
    expect_wr("R6 saturated length", 0, 1, 7, 'h0ABC, 255, 0);
  endtask

  task automatic t_resp();
    put_cmd(3, 9, 'h9999, 9); tick(); expect_none("R4 response not written");
    put_cmd(1, 10, 5, 10); tick(); expect_wr("R4 store after response", 1, 1, 10, 5, 0, 10);
    put_beat(4, 'hFFFF, 0, 1); tick(); expect_none("R4 response transfer no patch");
    put_beat(1, 1, 0, 1); tick(); expect_wr("R4 aligned store patch", 0, 0, 10, 0, 'h02, 0);
  endtask

  task automatic t_prio();
    put_cmd(1, 11, 'h0B, 11); tick(); expect_wr("R8 store first", 1, 1, 11, 'h0B, 0, 11);
    put_beat(0, 1, 0, 1); put_cmd(0, 12, 'h0C, 12); tick();
    expect_wr("R8 command wins", 1, 1, 12, 'h0C, 0, 12);
    tick(); expect_wr("R8 patch later", 0, 0, 11, 0, 'h01, 0);
    tick(); expect_none("R8 nothing left");
  endtask

  task automatic t_order();
    for (int k = 0; k < 3; k++) begin
      put_cmd(1, 13 + k, 'h100 + k, k); tick();
      expect_wr("R9 store first", 1, 1, 13 + k, 'h100 + k, 0, k);
    end
    for (int k = 0; k < 3; k++) begin
      put_beat(k + 1, 'h8, 0, 1); put_cmd(0, 20 + k, 'h200 + k, 'h20 + k); tick();
      expect_wr("R9 busy port", 1, 1, 20 + k, 'h200 + k, 0, 'h20 + k);
    end
    for (int k = 0; k < 3; k++) begin
      tick(); expect_wr("R9 drain order", 0, 0, 13 + k, 0, 1 << (k + 1), 0);
    end
    tick(); expect_none("R9 drained");
  endtask

  task automatic t_overflow();
    for (int k = 1; k <= 5; k++) begin
      put_cmd(1, k, 'h300 + k, k); tick();
    end
    for (int k = 1; k <= 5; k++) begin
      put_beat(k - 1, 'h10, 0, 1); put_cmd(0, 23 + k, 'h400 + k, k); tick();
      expect_wr("R10 busy port", 1, 1, 23 + k, 'h400 + k, 0, k);
    end
    for (int k = 2; k <= 5; k++) begin
      tick(); expect_wr("R10 survivors", 0, 0, k, 0, 1 << (k - 1), 0);
    end
    tick(); expect_none("R10 oldest lost");
  endtask

  task automatic t_ignore();
    put_beat(6, 'hFFFF, 'h5555, 0); tick(); expect_none("R11 stray beat");
    put_beat(3, 'hFFFF, 'h5555, 1); tick(); expect_none("R11 stray eow beat");
    tick(); expect_none("R11 still idle");
    put_cmd(1, 8, 'h88, 8); tick(); expect_wr("R11 store first", 1, 1, 8, 'h88, 0, 8);
    put_beat(6, 'h8000, 0, 1); tick(); expect_wr("R11 clean mask", 0, 0, 8, 0, 'h40, 0);
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    checks++;
    if (wr_en !== 1'b0) begin
      fails++; $display("FAIL R1 in reset: wr_en=%b expected 0", wr_en);
    end
    rst_n = 1;
    t_reset();
    t_plain();
    t_store();
    t_dma();
    t_dma_sat();
    t_resp();
    t_prio();
    t_order();
    t_overflow();
    t_ignore();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule